// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-sensitive service requests from up to sixteen peripherals and decides whether the processor should be interrupted. Each source has an enable bit, a 4-bit priority and a handler address, all set through a simple register bus. A lower priority value means a more urgent source. When several enabled sources request at once, the most urgent one wins. If two have the same priority, the one with the lower index wins.

The interrupt line goes high only when the winner is strictly more urgent than the handler that is running now. Software reads the vector register to get the winner's handler address directly. That read also acknowledges the interrupt: the winner's priority is pushed onto an in-service stack and becomes the running priority. Any write to the end-of-interrupt register pops the stack and brings back the previous running level. This lets handlers nest by priority.

Registers are 32-bit words, selected by a 6-bit word index:

| Index | Register | Access |
|---|---|---|
| 0x00 | raw request status | read |
| 0x01 | enable bits | read/write |
| 0x02 | masked status | read |
| 0x03 | vector (reading it acknowledges) | read |
| 0x04 | end of interrupt | write |
| 0x05 | default vector | read/write |
| 0x06 | running state | read |
| 0x10+i | priority of source i | read/write |
| 0x20+i | handler address of source i | read/write |

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable bits, all priorities, all handler addresses and the default vector are zero, the in-service stack is empty, and `irq_o` is low.
- R2: Word 0x00 reads the live request inputs, one bit per source. Word 0x02 reads those requests ANDed with the enable bits.
- R3: Word 0x01 holds the per-source enable bits (bit i enables source i). A disabled source never raises `irq_o` and never wins the vector read.
- R4: Words 0x10+i (priority, bits 3:0) and 0x20+i (handler address) are writable and read back as written. Word 0x05 works the same way for the default vector.
- R5: Among pending enabled sources, the winner has the lowest priority value. On a tie, the lower source index wins.
- R6: `irq_o` is a register. It is high in the cycle after a clock edge at which a winner existed and either the stack was empty or the winner's value was strictly below the top of the stack. Otherwise it is low.
- R7: When a read of word 0x03 finds a qualifying winner, it returns that source's handler address and pushes the winner's priority onto the in-service stack. Word 0x06 then shows that priority in bits 3:0, bit 7 set (stack not empty), and the stack depth in bits 12:8.
- R8: When a read of word 0x03 finds no qualifying winner, it returns the default vector and leaves the stack unchanged.
- R9: Any write to word 0x04 pops one stack entry, and the previous priority becomes the running one. A write to 0x04 with an empty stack changes nothing.
- R10: A pending source whose priority equals the running priority does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Level request from each source |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, valid in the same cycle |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench goes after these corner cases:

- **Equal priority.** A request at exactly the running priority must stay silent. A design that compares with less-or-equal would re-enter the same level.
- **Equal-priority tie.** Two requests with the same value must resolve to the lower index. An arbiter that scans the wrong way or keeps the later match returns the wrong handler address.
- **Read with nothing qualifying.** A vector read with no qualifying request must return the default vector and leave the depth unchanged. A design that pushes anyway corrupts the nesting.
- **Unwinding the stack.** Several end-of-interrupt writes, including one on an empty stack, must restore each earlier running level in turn and must not underflow.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC  = 16,
  parameter int PW    = 4,
  parameter int HW    = 32,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [5:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o
);
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [5:0] A_RAW = 6'h00, A_EN  = 6'h01, A_MSK = 6'h02, A_VEC = 6'h03,
                         A_EOI = 6'h04, A_DEF = 6'h05, A_RUN = 6'h06,
                         A_PRI = 6'h10, A_HND = 6'h20;

  logic [NSRC-1:0] en_q;
  logic [PW-1:0]   pri_q [NSRC];
  logic [HW-1:0]   hnd_q [NSRC];
  logic [HW-1:0]   def_q;
  logic [PW-1:0]   stk_q [DEPTH];
  logic [SPW-1:0]  sp;
  logic            irq_q;

  wire [NSRC-1:0] pend      = irq_src & en_q;
  wire            stk_empty = (sp == '0);

  logic          found;
  logic [IW-1:0] win;
  logic [PW-1:0] win_pri;

  always_comb begin
    found   = 1'b0;
    win     = '0;
    win_pri = '1;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && (!found || pri_q[i] < win_pri)) begin
        found   = 1'b1;
        win     = IW'(i);
        win_pri = pri_q[i];
      end
  end

  wire qual   = found && (stk_empty || win_pri < stk_q[0]);
  wire rd_vec = bus_sel && !bus_wr && bus_addr == A_VEC;
  wire wr_eoi = bus_sel && bus_wr && bus_addr == A_EOI;
  wire push   = rd_vec && qual && sp != SPW'(DEPTH);
  wire pop    = wr_eoi && !stk_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      def_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        pri_q[i] <= '0;
        hnd_q[i] <= '0;
      end
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == A_EN)  en_q  <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_DEF) def_q <= bus_wdata[HW-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (bus_addr == A_PRI + 6'(i)) pri_q[i] <= bus_wdata[PW-1:0];
        if (bus_addr == A_HND + 6'(i)) hnd_q[i] <= bus_wdata[HW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push) begin
      stk_q[0] <= win_pri;
      for (int i = 1; i < DEPTH; i++) stk_q[i] <= stk_q[i-1];
      sp <= sp + 1'b1;
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) stk_q[i] <= stk_q[i+1];
      stk_q[DEPTH-1] <= '0;
      sp <= sp - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= qual;

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RAW: bus_rdata[NSRC-1:0] = irq_src;
      A_EN:  bus_rdata[NSRC-1:0] = en_q;
      A_MSK: bus_rdata[NSRC-1:0] = pend;
      A_VEC: bus_rdata[HW-1:0]   = qual ? hnd_q[win] : def_q;
      A_DEF: bus_rdata[HW-1:0]   = def_q;
      A_RUN: begin
        bus_rdata[PW-1:0]  = stk_empty ? '0 : stk_q[0];
        bus_rdata[7]       = !stk_empty;
        bus_rdata[8+:SPW]  = sp;
      end
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (bus_addr == A_PRI + 6'(i)) bus_rdata[PW-1:0] = pri_q[i];
          if (bus_addr == A_HND + 6'(i)) bus_rdata[HW-1:0] = hnd_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC  = 16,
  parameter int DEPTH = 16,
  parameter int SPW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_src,
  input logic [NSRC-1:0] en_q,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [5:0]      bus_addr,
  input logic            irq_o,
  input logic            qual,
  input logic [SPW-1:0]  sp
);
  wire vec_rd = bus_sel && !bus_wr && bus_addr == 6'h03;
  wire eoi_wr = bus_sel && bus_wr && bus_addr == 6'h04;

  a_r7_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && qual && sp != SPW'(DEPTH)) |=> sp == $past(sp) + 1'b1);

  a_r8_default_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !qual) |=> $stable(sp));

  a_r9_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && sp != '0) |=> sp == $past(sp) - 1'b1);

  a_r9_empty_eoi_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && sp == '0) |=> sp == '0);

  a_r3_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(irq_src & en_q)));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .DEPTH(DEPTH), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .en_q(en_q), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .irq_o(irq_o), .qual(qual), .sp(sp)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        bsel = 1'b0, bwr = 1'b0;
  logic [5:0]  baddr = '0;
  logic [31:0] bwd = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0, fails = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_sel(bsel), .bus_wr(bwr),
    .bus_addr(baddr), .bus_wdata(bwd), .bus_rdata(rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  int          m_pri [16];
  logic [31:0] m_hnd [16];
  logic [15:0] m_en;
  logic [31:0] m_def;
  int          m_stk [$];
  logic        irq_exp;

  function automatic int m_best();
    int b = -1;
    for (int i = 0; i < 16; i++)
      if (src[i] && m_en[i] && (b < 0 || m_pri[i] < m_pri[b])) b = i;
    return b;
  endfunction

  function automatic bit m_qual();
    int b = m_best();
    return b >= 0 && (m_stk.size() == 0 || m_pri[b] < m_stk[0]);
  endfunction

  function automatic logic [31:0] m_read(input logic [5:0] a);
    logic [31:0] r = '0;
    if (a == 6'h00) r = {16'h0, src};
    else if (a == 6'h01) r = {16'h0, m_en};
    else if (a == 6'h02) r = {16'h0, src & m_en};
    else if (a == 6'h03) r = m_qual() ? m_hnd[m_best()] : m_def;
    else if (a == 6'h05) r = m_def;
    else if (a == 6'h06) begin
      if (m_stk.size() > 0) begin r[3:0] = 4'(m_stk[0]); r[7] = 1'b1; end
      r[12:8] = 5'(m_stk.size());
    end
    else if (a[5:4] == 2'b01) r = 32'(m_pri[a[3:0]]);
    else if (a[5:4] == 2'b10) r = m_hnd[a[3:0]];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_def = '0; m_stk.delete(); irq_exp = 1'b0;
      for (int i = 0; i < 16; i++) begin m_pri[i] = 0; m_hnd[i] = '0; end
    end else begin
      bit q;
      int b;
      q = m_qual();
      b = m_best();
      if (bsel && bwr) begin
        if (baddr == 6'h01) m_en = bwd[15:0];
        if (baddr == 6'h05) m_def = bwd;
        if (baddr[5:4] == 2'b01) m_pri[baddr[3:0]] = int'(bwd[3:0]);
        if (baddr[5:4] == 2'b10) m_hnd[baddr[3:0]] = bwd;
        if (baddr == 6'h04 && m_stk.size() > 0) void'(m_stk.pop_front());
      end
      if (bsel && !bwr && baddr == 6'h03 && q && m_stk.size() < 16)
        m_stk.push_front(m_pri[b]);
      irq_exp = q;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R6 R10: the interrupt line is compared with the model on every clock
  always @(negedge clk)
    if (rst_n) check("R6/R10 irq_o", {31'b0, irq_o}, {31'b0, irq_exp});

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bsel = 1'b1; bwr = 1'b1; baddr = a; bwd = d;
    @(negedge clk);
    bsel = 1'b0; bwr = 1'b0;
  endtask

  task automatic rdc(input logic [5:0] a, input string tag);
    logic [31:0] e;
    bsel = 1'b1; bwr = 1'b0; baddr = a;
    #1;
    e = m_read(a);
    check(tag, rdata, e);
    @(negedge clk);
    bsel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rdc(6'h01, "R1 enable");
    rdc(6'h06, "R1 running");
    rdc(6'h00, "R1 raw");
    rdc(6'h03, "R1 vector");
    rdc(6'h17, "R1 priority");

    for (int i = 0; i < 16; i++) wr(6'h10 + 6'(i), 32'((i * 5) % 16));
    for (int i = 0; i < 16; i++) wr(6'h20 + 6'(i), 32'h8000_0000 + 32'(i) * 32'h40);
    wr(6'h05, 32'hDEAD_0000);
    rdc(6'h13, "R4 priority");
    rdc(6'h27, "R4 handler");
    rdc(6'h05, "R4 default");

    src = 16'h0A50; idle(2);
    rdc(6'h00, "R2 raw");
    rdc(6'h02, "R3 masked all off");
    rdc(6'h03, "R3 vector while masked");

    wr(6'h01, 32'h0000_0050); idle(2);
    rdc(6'h02, "R2 masked");
    rdc(6'h03, "R5 R7 vector ack");
    rdc(6'h06, "R7 running");
    idle(2);

    wr(6'h01, 32'h0000_FFFF); idle(2);
    rdc(6'h03, "R8 R10 vector equal level");
    rdc(6'h06, "R8 stack kept");

    src = src | 16'h2000; idle(2);
    rdc(6'h03, "R5 nested vector");
    wr(6'h1A, 32'h0); idle(1);
    src = src | 16'h0401; idle(2);
    rdc(6'h03, "R5 tie lower index");
    rdc(6'h06, "R7 depth three");

    wr(6'h04, 32'h0); rdc(6'h06, "R9 pop one");
    wr(6'h04, 32'h1234); rdc(6'h06, "R9 pop two");
    wr(6'h04, 32'h0); rdc(6'h06, "R9 pop three");
    idle(2);
    src = '0; idle(2);
    rdc(6'h03, "R8 default empty");
    wr(6'h04, 32'h0); rdc(6'h06, "R9 eoi on empty");
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule